// File: doc/BRIEF.md
# Column-Truncated Variable-Precision Multiplier

This block multiplies two 24-bit unsigned operands and returns only the upper 24 bits of the 48-bit product. The partial-product bits that fall in the low product columns (0 to 22) are never built. A runtime precision setting switches off further low columns, beginning at the lowest built column. To make up for the average error of the missing columns, a small correction constant is added at column 23 through the carry-in path of the summation. Software loads the precision and the constant together through one configuration strobe.

Each operand pair is presented with a one-cycle valid pulse. It passes through an operand register and then through a result register, so a new pair can enter every cycle. Compared with the exact product, the result may be wrong by one to a few low-order bits. That error is the price of the lower switching activity. Computing the constant is left to software.

Top module: `vprec_trunc_mul`

## Requirements
- R1: After reset `out_valid` is 0 and `out_prod` is 0. The settings are precision 24 and correction 0.
- R2: For an operand pair sampled with `in_valid` high at clock edge N, `out_valid` is high for exactly one cycle after edge N+1. Pairs on consecutive cycles give results on consecutive cycles, in the same order.
- R3: The result is bits [47:24] of S modulo 2^48. S is the sum of a[i]·b[j]·2^(i+j) over all i+j ≥ 47−p, plus corr·2^23. Here p is the effective precision and corr is the 8-bit correction.
- R4: A partial product in any column below 23 never affects the result, whatever the precision.
- R5: Precision p gates columns 23 through 46−p. At p=8 only columns 39 and above remain, so a product bit in column 38 has no effect and one in column 39 does.
- R6: The precision field `cfg_prec` is 5 bits wide. A value below 8 acts as 8, and a value above 24 acts as 24.
- R7: A `cfg_we` pulse at edge N loads both `cfg_prec` and `cfg_corr`. Operands sampled at edge N+1 or later use the new settings. Operands sampled at edge N itself use the previous settings.
- R8: The correction is aligned to product bit 23. A zero operand therefore gives `corr[7:1]`, and a sum that exceeds 48 bits wraps.
- R9: While `out_valid` is low, `out_prod` holds its last value. With `cfg_we` low, the settings do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load strobe for the precision and the correction |
| cfg_prec | input | 5 | Requested precision in bits (8 to 24 effective) |
| cfg_corr | input | 8 | Correction constant, aligned to product column 23 |
| in_valid | input | 1 | Operand pair present |
| in_a | input | 24 | Multiplicand |
| in_b | input | 24 | Multiplier |
| out_valid | output | 1 | Result present |
| out_prod | output | 24 | Truncated upper product |

## Verification
Single-bit operands are placed so that their only partial product sits exactly on a column boundary: column 22 against 23, and column 38 against 39 at the lowest precision. These show whether the built-column limit and the gating threshold are off by one. All-ones operands with the largest correction test the carry out of the kept columns and the wrap at 48 bits. Zero operands isolate the correction path. A configuration write in the same cycle as an operand tells apart whether the settings are registered or pass straight through. Out-of-range precision codes and a pseudo-random sweep over many precisions and correction values test the clamping and the general sum.

// File: rtl/vprec_pkg.sv
package vprec_pkg;

    // Clamp a requested precision into [lo, hi].
    function automatic int unsigned clamp_prec(input int unsigned req,
                                               input int unsigned lo,
                                               input int unsigned hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/vprec_cfg.sv
module vprec_cfg
    import vprec_pkg::*;
#(
    parameter int W     = 24,
    parameter int CW    = 8,
    parameter int PMIN  = 8,
    parameter int PRW   = $clog2(W + 1),
    parameter int THRW  = $clog2(2 * W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [PRW-1:0]  cfg_prec,
    input  logic [CW-1:0]   cfg_corr,
    output logic [PRW-1:0]  prec_q,
    output logic [CW-1:0]   corr_q,
    output logic [THRW-1:0] keep_from
);

    logic [PRW-1:0] prec_eff;

    always_comb begin
        prec_eff = PRW'(clamp_prec(int'(cfg_prec), PMIN, W));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prec_q <= PRW'(W);
            corr_q <= '0;
        end else if (cfg_we) begin
            prec_q <= prec_eff;
            corr_q <= cfg_corr;
        end
    end

    // The lowest product column that stays on is 2W-1-p.
    always_comb begin
        keep_from = THRW'(2 * W - 1) - THRW'(prec_q);
    end

endmodule

// File: rtl/vprec_col_mask.sv
module vprec_col_mask #(
    parameter int W    = 24,
    parameter int THRW = $clog2(2 * W)
) (
    input  logic [THRW-1:0] keep_from,
    output logic [2*W-1:0]  col_on
);

    localparam int PW    = 2 * W;
    localparam int BUILT = W - 1;

    for (genvar k = 0; k < PW; k++) begin : g_col
        if (k < BUILT) begin : g_absent
            assign col_on[k] = 1'b0;
        end else begin : g_gated
            assign col_on[k] = (THRW'(k) >= keep_from);
        end
    end

endmodule

// File: rtl/vprec_trunc_array.sv
module vprec_trunc_array #(
    parameter int W  = 24,
    parameter int CW = 8
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic [2*W-1:0] col_on,
    input  logic [CW-1:0]  corr,
    output logic [W-1:0]   prod_hi
);

    localparam int PW    = 2 * W;
    localparam int BUILT = W - 1;

    logic [PW-1:0] rows [W];
    logic [PW-1:0] acc;

    // Partial-product bits exist only in columns BUILT and above.
    for (genvar j = 0; j < W; j++) begin : g_row
        for (genvar k = 0; k < PW; k++) begin : g_bit
            if ((k >= BUILT) && (k - j >= 0) && (k - j < W)) begin : g_pp
                assign rows[j][k] = op_a[k-j] & op_b[j] & col_on[k];
            end else begin : g_zero
                assign rows[j][k] = 1'b0;
            end
        end
    end

    always_comb begin
        acc = PW'({corr, {BUILT{1'b0}}});
        for (int j = 0; j < W; j++) begin
            acc = acc + rows[j];
        end
        prod_hi = acc[PW-1:W];
    end

endmodule

// File: rtl/vprec_trunc_mul.sv
module vprec_trunc_mul #(
    parameter int W    = 24,
    parameter int CW   = 8,
    parameter int PMIN = 8,
    parameter int PRW  = $clog2(W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [PRW-1:0] cfg_prec,
    input  logic [CW-1:0]  cfg_corr,
    input  logic           in_valid,
    input  logic [W-1:0]   in_a,
    input  logic [W-1:0]   in_b,
    output logic           out_valid,
    output logic [W-1:0]   out_prod
);

    localparam int PW   = 2 * W;
    localparam int THRW = $clog2(PW);

    logic [PRW-1:0]  prec_q;
    logic [CW-1:0]   corr_q;
    logic [THRW-1:0] keep_from;
    logic [PW-1:0]   col_on;

    logic            s1_valid;
    logic [W-1:0]    s1_a;
    logic [W-1:0]    s1_b;
    logic [PW-1:0]   s1_col_on;
    logic [CW-1:0]   s1_corr;
    logic [W-1:0]    prod_hi;

    vprec_cfg #(.W(W), .CW(CW), .PMIN(PMIN), .PRW(PRW), .THRW(THRW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_prec  (cfg_prec),
        .cfg_corr  (cfg_corr),
        .prec_q    (prec_q),
        .corr_q    (corr_q),
        .keep_from (keep_from)
    );

    vprec_col_mask #(.W(W), .THRW(THRW)) u_mask (
        .keep_from (keep_from),
        .col_on    (col_on)
    );

    // Operand stage: the settings in force at this edge travel with the pair.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_a      <= '0;
            s1_b      <= '0;
            s1_col_on <= '0;
            s1_corr   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_a      <= in_a;
                s1_b      <= in_b;
                s1_col_on <= col_on;
                s1_corr   <= corr_q;
            end
        end
    end

    vprec_trunc_array #(.W(W), .CW(CW)) u_array (
        .op_a    (s1_a),
        .op_b    (s1_b),
        .col_on  (s1_col_on),
        .corr    (s1_corr),
        .prod_hi (prod_hi)
    );

    // Result stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_prod  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_prod <= prod_hi;
            end
        end
    end

endmodule

module vprec_trunc_mul_chk #(
    parameter int W    = 24,
    parameter int CW   = 8,
    parameter int PMIN = 8,
    parameter int PRW  = $clog2(W + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_we,
    input logic           in_valid,
    input logic [W-1:0]   in_a,
    input logic [W-1:0]   in_b,
    input logic           out_valid,
    input logic [W-1:0]   out_prod,
    input logic [PRW-1:0] prec_q,
    input logic [CW-1:0]  corr_q
);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    // R2
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R9
    hold_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_prod));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(prec_q) && $stable(corr_q)));

    // R6
    prec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(prec_q) >= PMIN) && (int'(prec_q) <= W));

    // R8
    zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid && ((in_a == '0) || (in_b == '0)), 2))
        |-> (out_prod == W'($past(corr_q[CW-1:1], 2))));

endmodule

bind vprec_trunc_mul vprec_trunc_mul_chk #(.W(W), .CW(CW), .PMIN(PMIN), .PRW(PRW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_prod  (out_prod),
    .prec_q    (prec_q),
    .corr_q    (corr_q)
);

// File: tb/vprec_trunc_mul_bench.sv
module vprec_trunc_mul_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 24;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [4:0]   cfg_prec = '0;
    logic [7:0]   cfg_corr = '0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0;
    logic [W-1:0] in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_prod;

    int checks = 0;
    int fails  = 0;
    item_t sb[$];
    logic [W-1:0] last_exp = '0;
    int   m_prec = 24;
    logic [7:0] m_corr = '0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vprec_trunc_mul u_vprec_trunc_mul (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_prec(cfg_prec),
        .cfg_corr(cfg_corr), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_prod(out_prod)
    );

    function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                           int p, logic [7:0] c);
        logic [48:0] s;
        int pe;
        pe = (p < 8) ? 8 : ((p > 24) ? 24 : p);
        s = 49'(c) << 23;
        for (int i = 0; i < W; i++)
            for (int j = 0; j < W; j++)
                if ((i + j >= 47 - pe) && a[i] && b[j])
                    s = s + (49'(1) << (i + j));
        return s[47:24];
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(logic [W-1:0] a, logic [W-1:0] b, string tag);
        item_t it;
        in_valid = 1'b1; in_a = a; in_b = b;
        it.exp = model(a, b, m_prec, m_corr); it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic cfg(int p, logic [7:0] c);
        cfg_we = 1'b1; cfg_prec = 5'(p); cfg_corr = c;
        @(negedge clk);
        cfg_we = 1'b0;
        m_prec = p; m_corr = c;
    endtask

    // Configuration write and operand in the same cycle (R7).
    task automatic cfg_op(int p, logic [7:0] c, logic [W-1:0] a, logic [W-1:0] b);
        item_t it;
        cfg_we = 1'b1; cfg_prec = 5'(p); cfg_corr = c;
        in_valid = 1'b1; in_a = a; in_b = b;
        it.exp = model(a, b, m_prec, m_corr); it.tag = "R7 same-cycle write";
        sb.push_back(it);
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        m_prec = p; m_corr = c;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard as results appear.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected result", out_prod, 'x);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    check(it.tag, out_prod, it.exp);
                    last_exp = it.exp;
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out_valid after reset", {23'd0, out_valid}, '0);
        check("R1 out_prod after reset", out_prod, '0);
        op(24'hFFFFFF, 24'hFFFFFF, "R1 default settings");
        idle(3);

        // R3 main function
        cfg(24, 8'h80);
        op(24'hABCDEF, 24'h123456, "R3 full precision");
        op(24'h800001, 24'h7FFFFF, "R3 full precision 2");
        cfg(16, 8'h40);
        op(24'hABCDEF, 24'h123456, "R3 precision 16");
        idle(3);

        // R4 columns below 23 never count
        cfg(24, 8'h55);
        op(24'h000001, 24'h200000, "R4 column 21");
        op(24'h000800, 24'h000800, "R4 column 22");
        op(24'h001000, 24'h000800, "R4 column 23 kept");
        idle(3);

        // R5 boundary at lowest precision
        cfg(8, 8'h00);
        op(24'h100000, 24'h040000, "R5 column 38 gated");
        op(24'h100000, 24'h080000, "R5 column 39 kept");
        idle(3);

        // R6 clamping
        cfg(3, 8'h11);
        op(24'hFFFFFF, 24'hF0F0F0, "R6 precision 3 acts as 8");
        cfg(31, 8'h11);
        op(24'hFFFFFF, 24'hF0F0F0, "R6 precision 31 acts as 24");
        idle(3);

        // R7 settings timing
        cfg(24, 8'h00);
        cfg_op(10, 8'hF0, 24'hC3C3C3, 24'h5A5A5A);
        op(24'hC3C3C3, 24'h5A5A5A, "R7 next cycle uses new settings");
        idle(3);

        // R8 correction alignment and wrap
        cfg(24, 8'hFF);
        op(24'h000000, 24'h123456, "R8 zero operand");
        op(24'hFFFFFF, 24'hFFFFFF, "R8 wrap at 48 bits");
        idle(3);

        // R9 hold while idle
        idle(4);
        check("R9 output held", out_prod, last_exp);

        // R2 back-to-back burst
        cfg(20, 8'h33);
        op(24'h111111, 24'h222222, "R2 burst 0");
        op(24'h333333, 24'h444444, "R2 burst 1");
        op(24'h555555, 24'h666666, "R2 burst 2");
        op(24'hFEDCBA, 24'h987654, "R2 burst 3");
        idle(3);

        // R3 pseudo-random sweep
        for (int n = 0; n < 60; n++) begin
            logic [W-1:0] a;
            logic [W-1:0] b;
            if (n % 6 == 0) begin
                lfsr = lfsr * 32'd1664525 + 32'd1013904223;
                cfg(8 + int'(lfsr[27:24]) % 17, lfsr[15:8]);
            end
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            a = lfsr[31:8];
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            b = lfsr[31:8];
            op(a, b, "R3 sweep");
        end
        idle(4);
        check("R2 all results returned", 24'(sb.size()), '0);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule